// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits next to a two-port 32K-word memory and turns accesses to two fixed words at the top of the address space into interrupts between the ports. Each port presents an active-low chip enable, a read/write level (low means write), an active-low output enable and a 15-bit word address. When one port writes the word reserved as its partner's mailbox, an active-low interrupt flag is raised toward the partner. When the partner reads that word, its flag drops. The 16-bit message itself is held in the memory like any other word; this block never sees data.

The left port's mailbox is the word one below the top of memory (0x7FFE for 15 address bits), and the right port's mailbox is the top word (0x7FFF). A static enable input switches the whole function off, so that both words become plain storage with no side effect. The flags are registered: an access seen at a clock edge shows on the interrupt outputs just after that same edge.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset both `left_irq_n` and `right_irq_n` are high (deasserted).
- R2: A right-port write (`right_ce_n`=0, `right_rw_n`=0) to address 0x7FFE, with `irq_en`=1, drives `left_irq_n` low after the next rising clock edge.
- R3: A left-port write (`left_ce_n`=0, `left_rw_n`=0) to address 0x7FFF, with `irq_en`=1, drives `right_irq_n` low after the next rising clock edge.
- R4: A left-port access to 0x7FFE with `left_ce_n`=0 and `left_oe_n`=0 returns `left_irq_n` high after the next rising edge, whatever the level of `left_rw_n`.
- R5: A right-port access to 0x7FFF with `right_ce_n`=0 and `right_oe_n`=0 returns `right_irq_n` high after the next rising edge.
- R6: When the set and the clear of one flag fall in the same cycle, the flag ends up asserted (low).
- R7: Any access that is neither a set nor a clear leaves both flags unchanged: other addresses, a deselected port (`ce_n`=1), a port writing its own mailbox with `oe_n`=1, or a port reading its partner's mailbox.
- R8: While `irq_en`=0 both outputs are high and no access changes them; accesses made while disabled leave no pending flag once `irq_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | 1 enables the mailbox interrupt function |
| left_ce_n | input | 1 | Left port chip enable, active low |
| left_rw_n | input | 1 | Left port read/write, low = write |
| left_oe_n | input | 1 | Left port output enable, active low |
| left_addr | input | 15 | Left port word address |
| right_ce_n | input | 1 | Right port chip enable, active low |
| right_rw_n | input | 1 | Right port read/write, low = write |
| right_oe_n | input | 1 | Right port output enable, active low |
| right_addr | input | 15 | Right port word address |
| left_irq_n | output | 1 | Interrupt toward the left port, active low |
| right_irq_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The bench targets the accesses that look close to a mailbox event but are not one: a port reading its partner's mailbox, a port writing its own mailbox with output enable high, and hits on the neighbouring address; a design with a loose address compare or swapped mailbox words would raise or drop the wrong flag there. It also drives a simultaneous set and clear of one flag, where a clear-priority design would leave the interrupt lost, and a clear with read/write held low, which a design that insisted on a true read would ignore. Finally it toggles the enable around mailbox writes, catching a design that keeps flags alive or latches events while the function is off.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int unsigned MBOX_ADDR_W = 15;
   localparam int unsigned MBOX_PORTS  = 2;
   localparam int unsigned PORT_LEFT   = 0;
   localparam int unsigned PORT_RIGHT  = 1;

   typedef struct packed {
      logic ce_n;
      logic rw_n;
      logic oe_n;
   } port_ctl_t;

   typedef struct packed {
      logic set_peer;
      logic clr_own;
   } mbox_evt_t;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
   import mbox_pkg::*;
#(
   parameter int unsigned ADDR_W   = MBOX_ADDR_W,
   parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
   parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
   input  port_ctl_t         ctl,
   input  logic [ADDR_W-1:0] addr,
   output mbox_evt_t         evt
);
   initial begin
      if (OWN_BOX == PEER_BOX)
         $error("mbox_port_decode: mailbox addresses must differ");
   end

   logic selected;
   logic is_write;
   logic reads_out;

   always_comb begin
      selected     = ~ctl.ce_n;
      is_write     = selected & ~ctl.rw_n;
      reads_out    = selected & ~ctl.oe_n;
      evt.set_peer = is_write & (addr == PEER_BOX);
      evt.clr_own  = reads_out & (addr == OWN_BOX);
   end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic set_req,
   input  logic clr_req,
   output logic irq_n
);
   logic pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending <= 1'b0;
      else if (!enable)
         pending <= 1'b0;
      else if (set_req)
         pending <= 1'b1;
      else if (clr_req)
         pending <= 1'b0;
   end

   assign irq_n = ~pending;
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
   import mbox_pkg::*;
#(
   parameter int unsigned ADDR_W = MBOX_ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_en,
   input  logic              left_ce_n,
   input  logic              left_rw_n,
   input  logic              left_oe_n,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic              right_ce_n,
   input  logic              right_rw_n,
   input  logic              right_oe_n,
   input  logic [ADDR_W-1:0] right_addr,
   output logic              left_irq_n,
   output logic              right_irq_n
);
   localparam logic [ADDR_W-1:0] TOP_WORD  = '1;
   localparam logic [ADDR_W-1:0] LEFT_BOX  = TOP_WORD - 1'b1;
   localparam logic [ADDR_W-1:0] RIGHT_BOX = TOP_WORD;

   initial begin
      if (ADDR_W < 2)
         $error("mbox_irq_ctrl: ADDR_W must be at least 2");
   end

   port_ctl_t         ctl  [MBOX_PORTS];
   logic [ADDR_W-1:0] addr [MBOX_PORTS];
   mbox_evt_t         evt  [MBOX_PORTS];
   logic              irq_n[MBOX_PORTS];

   assign ctl[PORT_LEFT]   = '{ce_n: left_ce_n,  rw_n: left_rw_n,  oe_n: left_oe_n};
   assign ctl[PORT_RIGHT]  = '{ce_n: right_ce_n, rw_n: right_rw_n, oe_n: right_oe_n};
   assign addr[PORT_LEFT]  = left_addr;
   assign addr[PORT_RIGHT] = right_addr;

   for (genvar p = 0; p < MBOX_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] OWN  = (p == PORT_LEFT) ? LEFT_BOX  : RIGHT_BOX;
      localparam logic [ADDR_W-1:0] PEER = (p == PORT_LEFT) ? RIGHT_BOX : LEFT_BOX;
      localparam int unsigned       OTHER = MBOX_PORTS - 1 - p;

      mbox_port_decode #(
         .ADDR_W  (ADDR_W),
         .OWN_BOX (OWN),
         .PEER_BOX(PEER)
      ) u_dec (
         .ctl (ctl[p]),
         .addr(addr[p]),
         .evt (evt[p])
      );

      mbox_irq_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (irq_en),
         .set_req(evt[OTHER].set_peer),
         .clr_req(evt[p].clr_own),
         .irq_n  (irq_n[p])
      );
   end

   assign left_irq_n  = irq_n[PORT_LEFT];
   assign right_irq_n = irq_n[PORT_RIGHT];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_en,
   input logic              left_ce_n,
   input logic              left_rw_n,
   input logic              left_oe_n,
   input logic [ADDR_W-1:0] left_addr,
   input logic              right_ce_n,
   input logic              right_rw_n,
   input logic              right_oe_n,
   input logic [ADDR_W-1:0] right_addr,
   input logic              left_irq_n,
   input logic              right_irq_n
);
   localparam logic [ADDR_W-1:0] RBOX = '1;
   localparam logic [ADDR_W-1:0] LBOX = RBOX - 1'b1;

   logic l_set, l_clr, r_set, r_clr;
   assign l_set = !right_ce_n && !right_rw_n && (right_addr == LBOX);
   assign r_set = !left_ce_n  && !left_rw_n  && (left_addr  == RBOX);
   assign l_clr = !left_ce_n  && !left_oe_n  && (left_addr  == LBOX);
   assign r_clr = !right_ce_n && !right_oe_n && (right_addr == RBOX);

   // R2 R6
   left_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && l_set) |=> !left_irq_n);

   // R3 R6
   right_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && r_set) |=> !right_irq_n);

   // R4
   left_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && l_clr && !l_set) |=> left_irq_n);

   // R5
   right_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && r_clr && !r_set) |=> right_irq_n);

   // R7
   left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && !l_set && !l_clr) |=> $stable(left_irq_n));

   // R7
   right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && !r_set && !r_clr) |=> $stable(right_irq_n));

   // R8
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> (left_irq_n && right_irq_n));
endmodule

bind mbox_irq_ctrl mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbox_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mbox_irq_ctrl;
   localparam int AW = 15;
   localparam logic [AW-1:0] LBOX = 15'h7FFE;
   localparam logic [AW-1:0] RBOX = 15'h7FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_en = 1'b1;
   logic l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
   logic r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_irq_n, r_irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mbox_irq_ctrl #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
      .left_ce_n(l_ce_n), .left_rw_n(l_rw_n), .left_oe_n(l_oe_n), .left_addr(l_addr),
      .right_ce_n(r_ce_n), .right_rw_n(r_rw_n), .right_oe_n(r_oe_n), .right_addr(r_addr),
      .left_irq_n(l_irq_n), .right_irq_n(r_irq_n)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic idle();
      l_ce_n = 1; l_rw_n = 1; l_oe_n = 1; l_addr = '0;
      r_ce_n = 1; r_rw_n = 1; r_oe_n = 1; r_addr = '0;
   endtask

   // apply the current port drive for one edge, then return to idle
   task automatic step();
      @(posedge clk); #1;
      @(negedge clk);
      idle();
   endtask

   task automatic left_acc(input logic ce, input logic rw, input logic oe, input logic [AW-1:0] a);
      @(negedge clk);
      l_ce_n = ce; l_rw_n = rw; l_oe_n = oe; l_addr = a;
      step();
   endtask

   task automatic right_acc(input logic ce, input logic rw, input logic oe, input logic [AW-1:0] a);
      @(negedge clk);
      r_ce_n = ce; r_rw_n = rw; r_oe_n = oe; r_addr = a;
      step();
   endtask

   task automatic t_reset();
      check("R1 left reset", l_irq_n, 1'b1);
      check("R1 right reset", r_irq_n, 1'b1);
   endtask

   task automatic t_left_flag();
      right_acc(0, 0, 1, LBOX);
      check("R2 left set", l_irq_n, 1'b0);
      check("R2 right untouched", r_irq_n, 1'b1);
      left_acc(0, 1, 0, LBOX);
      check("R4 left clear read", l_irq_n, 1'b1);
      right_acc(0, 0, 1, LBOX);
      left_acc(0, 0, 0, LBOX);
      check("R4 left clear rw low", l_irq_n, 1'b1);
   endtask

   task automatic t_right_flag();
      left_acc(0, 0, 1, RBOX);
      check("R3 right set", r_irq_n, 1'b0);
      check("R3 left untouched", l_irq_n, 1'b1);
      right_acc(0, 1, 0, RBOX);
      check("R5 right clear", r_irq_n, 1'b1);
   endtask

   task automatic t_no_effect();
      left_acc(0, 0, 1, RBOX);
      right_acc(0, 0, 1, LBOX);
      left_acc(0, 1, 0, RBOX);
      check("R7 left reads peer box", r_irq_n, 1'b0);
      right_acc(0, 1, 0, LBOX);
      check("R7 right reads peer box", l_irq_n, 1'b0);
      left_acc(0, 0, 1, LBOX);
      check("R7 left writes own box oe high", l_irq_n, 1'b0);
      left_acc(1, 1, 0, LBOX);
      check("R7 left deselected", l_irq_n, 1'b0);
      right_acc(0, 1, 0, 15'h7FFD);
      left_acc(0, 1, 0, 15'h0FFE);
      check("R7 other addr left", l_irq_n, 1'b0);
      check("R7 other addr right", r_irq_n, 1'b0);
      left_acc(0, 1, 0, LBOX);
      right_acc(0, 1, 0, RBOX);
      idle();
      left_acc(0, 0, 1, 15'h7FFD);
      right_acc(0, 0, 1, 15'h3FFE);
      check("R7 near-miss write left", l_irq_n, 1'b1);
      check("R7 near-miss write right", r_irq_n, 1'b1);
   endtask

   task automatic t_collide();
      @(negedge clk);
      r_ce_n = 0; r_rw_n = 0; r_oe_n = 1; r_addr = LBOX;
      l_ce_n = 0; l_rw_n = 1; l_oe_n = 0; l_addr = LBOX;
      step();
      check("R6 left set wins", l_irq_n, 1'b0);
      left_acc(0, 1, 0, LBOX);
      check("R6 left clear after", l_irq_n, 1'b1);
      @(negedge clk);
      l_ce_n = 0; l_rw_n = 0; l_oe_n = 1; l_addr = RBOX;
      r_ce_n = 0; r_rw_n = 1; r_oe_n = 0; r_addr = RBOX;
      step();
      check("R6 right set wins", r_irq_n, 1'b0);
      right_acc(0, 1, 0, RBOX);
   endtask

   task automatic t_disable();
      left_acc(0, 0, 1, RBOX);
      @(negedge clk); irq_en = 0;
      @(posedge clk); #1;
      check("R8 disable drops right", r_irq_n, 1'b1);
      right_acc(0, 0, 1, LBOX);
      left_acc(0, 0, 1, RBOX);
      check("R8 disabled left", l_irq_n, 1'b1);
      check("R8 disabled right", r_irq_n, 1'b1);
      @(negedge clk); irq_en = 1;
      @(posedge clk); #1;
      check("R8 no stale left", l_irq_n, 1'b1);
      check("R8 no stale right", r_irq_n, 1'b1);
      right_acc(0, 0, 1, LBOX);
      check("R8 works after enable", l_irq_n, 1'b0);
      left_acc(0, 1, 0, LBOX);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1;
      t_left_flag();
      t_right_flag();
      t_no_effect();
      t_collide();
      t_disable();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule